// File: doc/BRIEF.md
# Descriptor Ring Walker for a DMA Channel

This block is the control side of a DMA channel that works from a ring of buffer descriptors held in word-addressed memory. Software builds each descriptor, sets its busy bit, writes the address of the first descriptor and turns the channel on. The engine reads the descriptor and hands the source, destination and length to a data mover over a request/done handshake. When the mover finishes, the engine writes the status word back with the busy bit cleared. It then either follows the next pointer or halts, if the descriptor carries a stop flag.

A descriptor is ten consecutive 32-bit words at word offsets 0 to 9: control (bit 31 = stop after this one), source, destination, length, status (bit 31 = busy), device status, tag, flags, requested length and next pointer. The engine keeps the address of the last descriptor it finished. A later start resumes at that descriptor's next pointer, or at the programmed first address while the register reads zero.

Registers, by word address on a 3-bit register port: 0 run control (bit 31 = run enable); 1 channel control (bit 0 = halt, reset value 1); 2 first-descriptor address; 3 last-finished address (readable and writable); 4 engine status (bit 0 = walking, read-only); 5 event bits, write-1-to-clear (bit 0 = disable acknowledge, bit 1 = chain end, bit 2 = empty-descriptor error). The state machine has seven states. IDLE waits for a start. RESOLVE reads the next pointer of the last finished descriptor. FETCH reads the ten words. EVAL decides on the busy bit. XFER waits on the mover. WRBACK writes the status back. LINK records completion and picks the next step. Transitions: IDLE to FETCH when the last-finished address is zero, otherwise IDLE to RESOLVE; RESOLVE to FETCH; FETCH to EVAL after word 9; EVAL to XFER when the busy bit is set, otherwise EVAL to IDLE with an error; XFER to WRBACK on done; WRBACK to LINK; LINK to FETCH to chain, or LINK to IDLE to halt.

Top module: `sg_chain_engine`

## Requirements
- R1: After reset, the channel halt bit reads 1, the last-finished address reads 0, the status and event registers read 0, and xfer_req and irq are low.
- R2: A walk starts only while run-control bit 31 is 1 and channel-control bit 0 is 0; either condition alone leaves the engine idle.
- R3: With the last-finished address at zero, a start fetches the descriptor at the first-descriptor address and presents its source (word 1), destination (word 2) and length (word 3) on the mover port.
- R4: After the mover signals done, the engine rewrites the status word (offset 4) with bit 31 cleared and the other bits kept, and loads the descriptor's address into the last-finished register.
- R5: A completed descriptor without the stop flag is followed by the one at its next pointer (offset 9), and the chain wraps around the ring.
- R6: A descriptor with control bit 31 set is still transferred and written back; the engine then halts, sets event bit 1 and sets channel-control bit 0.
- R7: Clearing run-control bit 31 during a transfer lets that descriptor complete and be written back, then the engine halts without fetching further, and event bit 0 is set.
- R8: A start with a nonzero last-finished address resumes at that descriptor's next pointer.
- R9: A fetched descriptor whose status bit 31 is clear is not transferred; the engine halts, sets event bit 2 and channel-control bit 0, and leaves the last-finished address unchanged.
- R10: Writing the event register clears exactly the bits written as 1; bits written as 0 are unchanged.
- R11: Status bit 0 reads 1 while the engine is walking the chain and 0 when idle.
- R12: irq is high exactly when any event bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_wr_en | output | 1 | Descriptor memory write strobe |
| mem_addr | output | 32 | Descriptor memory word address |
| mem_wdata | output | 32 | Descriptor memory write data |
| mem_rdata | input | 32 | Descriptor memory read data, same cycle |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_src | output | 32 | Transfer source address |
| xfer_dst | output | 32 | Transfer destination address |
| xfer_len | output | 32 | Transfer length |
| xfer_done | input | 1 | Data mover completion |
| irq | output | 1 | Any event bit set |

## Verification
The bench gates the start on each enable alone. An engine that ORs the two enables would begin a walk with the halt bit still set. It resumes from a nonzero last-finished address, where an engine that restarts at the first address would repeat a completed transfer. It lets a ring wrap back onto an already-completed descriptor, which must raise the empty-descriptor error with no extra transfer rather than send stale data again. It drops the run enable in the middle of a long transfer: aborting early would leave the status busy, and running on would fetch the next descriptor. It also clears one event bit while another is set, to catch a clear that wipes the whole register.

// File: rtl/sg_pkg.sv
package sg_pkg;
    localparam int DW       = 32;
    localparam int NWORDS   = 10;
    localparam int RAW      = 3;

    localparam int W_CTRL   = 0;
    localparam int W_SRC    = 1;
    localparam int W_DST    = 2;
    localparam int W_LEN    = 3;
    localparam int W_STAT   = 4;
    localparam int W_NEXT   = 9;

    localparam int STOP_BIT = 31;
    localparam int BUSY_BIT = 31;
    localparam int RUN_BIT  = 31;

    localparam logic [RAW-1:0] A_RUN   = 3'd0;
    localparam logic [RAW-1:0] A_CHCTL = 3'd1;
    localparam logic [RAW-1:0] A_FIRST = 3'd2;
    localparam logic [RAW-1:0] A_LAST  = 3'd3;
    localparam logic [RAW-1:0] A_STAT  = 3'd4;
    localparam logic [RAW-1:0] A_EVT   = 3'd5;

    localparam int EV_ACK = 0;
    localparam int EV_END = 1;
    localparam int EV_ERR = 2;
    localparam int NEV    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESOLVE,
        ST_FETCH,
        ST_EVAL,
        ST_XFER,
        ST_WRBACK,
        ST_LINK
    } sg_state_e;
endpackage

// File: rtl/sg_regs.sv
module sg_regs
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RAW-1:0]    wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [RAW-1:0]    rd_addr,
    output logic [DW-1:0]     rd_data,
    input  logic              busy,
    input  logic              set_ack,
    input  logic              set_end,
    input  logic              set_err,
    input  logic              set_halt,
    input  logic              last_we,
    input  logic [DW-1:0]     last_wd,
    output logic              run_en,
    output logic              sg_dis,
    output logic [DW-1:0]     first_addr,
    output logic [DW-1:0]     last_addr,
    output logic [NEV-1:0]    evt_q,
    output logic              irq
);
    logic [NEV-1:0] evt_set;
    logic           evt_wr;

    assign evt_set = {set_err, set_end, set_ack};
    assign evt_wr  = wr_en && (wr_addr == A_EVT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en     <= 1'b0;
            sg_dis     <= 1'b1;
            first_addr <= '0;
            last_addr  <= '0;
        end else begin
            if (wr_en && wr_addr == A_RUN)   run_en     <= wr_data[RUN_BIT];
            if (wr_en && wr_addr == A_FIRST) first_addr <= wr_data;
            if (set_halt)                    sg_dis     <= 1'b1;
            else if (wr_en && wr_addr == A_CHCTL) sg_dis <= wr_data[0];
            if (last_we)                     last_addr  <= last_wd;
            else if (wr_en && wr_addr == A_LAST) last_addr <= wr_data;
        end
    end

    for (genvar g = 0; g < NEV; g++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             evt_q[g] <= 1'b0;
            else if (evt_set[g])    evt_q[g] <= 1'b1;
            else if (evt_wr && wr_data[g]) evt_q[g] <= 1'b0;
        end
    end

    assign irq = |evt_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_RUN:   rd_data[RUN_BIT] = run_en;
            A_CHCTL: rd_data[0]       = sg_dis;
            A_FIRST: rd_data          = first_addr;
            A_LAST:  rd_data          = last_addr;
            A_STAT:  rd_data[0]       = busy;
            A_EVT:   rd_data[NEV-1:0] = evt_q;
            default: rd_data          = '0;
        endcase
    end

    // R10: a written 1 clears that bit when no event sets it in the same cycle
    p_w1c_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && wr_data[EV_END] && !set_end) |=> !evt_q[EV_END]);
    // R10: a written 0 leaves a set bit alone
    p_w1c_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_wr && !wr_data[EV_ERR] && evt_q[EV_ERR]) |=> evt_q[EV_ERR]);
endmodule

// File: rtl/sg_desc_store.sv
module sg_desc_store
    import sg_pkg::*;
#(
    parameter int IW = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [IW-1:0] cap_idx,
    input  logic [DW-1:0] cap_data,
    output logic          stop_flag,
    output logic [DW-1:0] src,
    output logic [DW-1:0] dst,
    output logic [DW-1:0] len,
    output logic [DW-1:0] stat,
    output logic [DW-1:0] nxt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_flag <= 1'b0;
            src  <= '0;
            dst  <= '0;
            len  <= '0;
            stat <= '0;
            nxt  <= '0;
        end else if (cap_en) begin
            if (cap_idx == IW'(W_CTRL)) stop_flag <= cap_data[STOP_BIT];
            if (cap_idx == IW'(W_SRC))  src  <= cap_data;
            if (cap_idx == IW'(W_DST))  dst  <= cap_data;
            if (cap_idx == IW'(W_LEN))  len  <= cap_data;
            if (cap_idx == IW'(W_STAT)) stat <= cap_data;
            if (cap_idx == IW'(W_NEXT)) nxt  <= cap_data;
        end
    end
endmodule

// File: rtl/sg_walker.sv
module sg_walker
    import sg_pkg::*;
#(
    parameter int IW = $clog2(NWORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          sg_dis,
    input  logic [DW-1:0] first_addr,
    input  logic [DW-1:0] last_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          xfer_done,
    input  logic          stop_flag,
    input  logic [DW-1:0] stat_word,
    input  logic [DW-1:0] next_ptr,
    output logic          busy,
    output logic          mem_rd_en,
    output logic          mem_wr_en,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          cap_en,
    output logic [IW-1:0] cap_idx,
    output logic          xfer_req,
    output logic          set_ack,
    output logic          set_end,
    output logic          set_err,
    output logic          set_halt,
    output logic          last_we,
    output logic [DW-1:0] last_wd
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

    sg_state_e     state, nxt_state;
    logic [DW-1:0] cur;
    logic [IW-1:0] idx;
    logic          start_ok;
    logic          halt_now;

    assign start_ok = run_en && !sg_dis;
    assign halt_now = stop_flag || !run_en || sg_dis;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:    if (start_ok) nxt_state = (last_addr == '0) ? ST_FETCH : ST_RESOLVE;
            ST_RESOLVE: nxt_state = ST_FETCH;
            ST_FETCH:   if (idx == LAST_IDX) nxt_state = ST_EVAL;
            ST_EVAL:    nxt_state = stat_word[BUSY_BIT] ? ST_XFER : ST_IDLE;
            ST_XFER:    if (xfer_done) nxt_state = ST_WRBACK;
            ST_WRBACK:  nxt_state = ST_LINK;
            ST_LINK:    nxt_state = halt_now ? ST_IDLE : ST_FETCH;
            default:    nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
            idx <= '0;
        end else begin
            idx <= (state == ST_FETCH) ? idx + 1'b1 : '0;
            if (state == ST_IDLE && last_addr == '0) cur <= first_addr;
            else if (state == ST_RESOLVE)           cur <= mem_rdata;
            else if (state == ST_LINK)              cur <= next_ptr;
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        mem_rd_en = (state == ST_RESOLVE) || (state == ST_FETCH);
        mem_wr_en = (state == ST_WRBACK);
        unique case (state)
            ST_RESOLVE: mem_addr = last_addr + DW'(W_NEXT);
            ST_WRBACK:  mem_addr = cur + DW'(W_STAT);
            default:    mem_addr = cur + {{(DW-IW){1'b0}}, idx};
        endcase
        mem_wdata = stat_word & ~(DW'(1) << BUSY_BIT);
        cap_en    = (state == ST_FETCH);
        cap_idx   = idx;
        xfer_req  = (state == ST_XFER);
        set_err   = (state == ST_EVAL) && !stat_word[BUSY_BIT];
        set_end   = (state == ST_LINK) && stop_flag;
        set_ack   = (state == ST_LINK) && !stop_flag && !run_en;
        set_halt  = set_err || set_end;
        last_we   = (state == ST_LINK);
        last_wd   = cur;
    end

    // R4: a status write-back only follows a mover completion
    p_wb_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(xfer_done));
    // R7: disable acknowledge follows the write-back of the current descriptor
    p_ack_after_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_ack |-> $past(mem_wr_en));
endmodule

// File: rtl/sg_chain_engine.sv
module sg_chain_engine
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic [2:0]        reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              xfer_req,
    output logic [31:0]       xfer_src,
    output logic [31:0]       xfer_dst,
    output logic [31:0]       xfer_len,
    input  logic              xfer_done,
    output logic              irq
);
    localparam int IW = $clog2(NWORDS);

    logic           busy, run_en, sg_dis;
    logic           set_ack, set_end, set_err, set_halt, last_we;
    logic [DW-1:0]  first_addr, last_addr, last_wd;
    logic [NEV-1:0] evt_q;
    logic           cap_en, stop_flag;
    logic [IW-1:0]  cap_idx;
    logic [DW-1:0]  stat_word, next_ptr;

    sg_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .busy(busy), .set_ack(set_ack), .set_end(set_end), .set_err(set_err),
        .set_halt(set_halt), .last_we(last_we), .last_wd(last_wd),
        .run_en(run_en), .sg_dis(sg_dis), .first_addr(first_addr),
        .last_addr(last_addr), .evt_q(evt_q), .irq(irq)
    );

    sg_desc_store #(.IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(mem_rdata),
        .stop_flag(stop_flag), .src(xfer_src), .dst(xfer_dst),
        .len(xfer_len), .stat(stat_word), .nxt(next_ptr)
    );

    sg_walker #(.IW(IW)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .run_en(run_en), .sg_dis(sg_dis),
        .first_addr(first_addr), .last_addr(last_addr),
        .mem_rdata(mem_rdata), .xfer_done(xfer_done),
        .stop_flag(stop_flag), .stat_word(stat_word), .next_ptr(next_ptr),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cap_en(cap_en), .cap_idx(cap_idx), .xfer_req(xfer_req),
        .set_ack(set_ack), .set_end(set_end), .set_err(set_err),
        .set_halt(set_halt), .last_we(last_we), .last_wd(last_wd)
    );

    // R2: a walk begins only when both enables allowed it
    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(run_en && !sg_dis));
    // R6: chain end is reported together with an idle engine
    p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q[EV_END]) |-> !busy);
    // R9: the empty-descriptor error leaves the engine idle
    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_q[EV_ERR]) |-> (!busy && !xfer_req));
    // R11: the mover is only asked while the engine walks
    p_xfer_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> busy);
endmodule

// File: tb/sg_chain_engine_bench.sv
module sg_chain_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        xfer_req;
    logic [31:0] xfer_src, xfer_dst, xfer_len;
    logic        xfer_done = 1'b0;
    logic        irq;

    logic [31:0] mem [256];
    int          nvec = 0;
    int          nfail = 0;
    int          hold = 1;
    int          wcnt = 0;
    int          nxfer = 0;
    logic [31:0] log_src [16];
    logic [31:0] log_dst [16];
    logic [31:0] log_len [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    sg_chain_engine u_sg_chain_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .xfer_req(xfer_req), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
        .xfer_len(xfer_len), .xfer_done(xfer_done), .irq(irq)
    );

    // memory write port and data mover model, both acting at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (mem_wr_en) mem[mem_addr[7:0]] = mem_wdata;
            xfer_done = 1'b0;
            if (xfer_req) begin
                wcnt++;
                if (wcnt >= hold) begin
                    if (nxfer < 16) begin
                        log_src[nxfer] = xfer_src;
                        log_dst[nxfer] = xfer_dst;
                        log_len[nxfer] = xfer_len;
                    end
                    nxfer++;
                    wcnt = 0;
                    xfer_done = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd_reg(3'd4, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic put_desc(input int b, input logic stop, input logic [31:0] src,
                            input logic [31:0] dst, input logic [31:0] len,
                            input logic [31:0] nx, input logic bsy);
        mem[b]   = {stop, 31'h0};
        mem[b+1] = src;
        mem[b+2] = dst;
        mem[b+3] = len;
        mem[b+4] = bsy ? 32'h8000_005A : 32'h0000_005A;
        mem[b+5] = 32'h0;
        mem[b+6] = 32'(b);
        mem[b+7] = 32'h0;
        mem[b+8] = len;
        mem[b+9] = nx;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(3'd1, v); chk("R1 halt bit", v, 32'h1);
        rd_reg(3'd3, v); chk("R1 last-finished", v, 32'h0);
        rd_reg(3'd4, v); chk("R1 status", v, 32'h0);
        rd_reg(3'd5, v); chk("R1 events", v, 32'h0);
        chk("R1 xfer_req", {31'h0, xfer_req}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        put_desc(16, 1'b1, 32'hA000_0010, 32'hB000_0010, 32'd64, 32'd32, 1'b1);
        wr_reg(3'd2, 32'd16);
        wr_reg(3'd0, 32'h8000_0000);
        repeat (5) @(negedge clk);
        rd_reg(3'd4, v); chk("R2 run only stays idle", v, 32'h0);
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd1, 32'h0);
        repeat (5) @(negedge clk);
        rd_reg(3'd4, v); chk("R2 halt clear only stays idle", v, 32'h0);
        chk("R2 no transfer", nxfer, 0);
        wr_reg(3'd0, 32'h8000_0000);
        @(negedge clk);
        rd_reg(3'd4, v); chk("R11 busy while walking", v, 32'h1);
        wait_idle();
        rd_reg(3'd4, v); chk("R11 idle after end", v, 32'h0);
        chk("R6 stop descriptor transferred", nxfer, 1);
        chk("R3 source", log_src[0], 32'hA000_0010);
        chk("R3 destination", log_dst[0], 32'hB000_0010);
        chk("R3 length", log_len[0], 32'd64);
        chk("R4 status written back", mem[20], 32'h0000_005A);
        rd_reg(3'd3, v); chk("R4 last-finished", v, 32'd16);
        rd_reg(3'd5, v); chk("R6 end event", v, 32'h2);
        rd_reg(3'd1, v); chk("R6 halt bit set", v, 32'h1);
        chk("R12 irq on event", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr_reg(3'd5, 32'h0);
        rd_reg(3'd5, v); chk("R10 zero write keeps", v, 32'h2);
        wr_reg(3'd5, 32'h2);
        rd_reg(3'd5, v); chk("R10 one write clears", v, 32'h0);
        chk("R12 irq low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_resume();
        logic [31:0] v;
        put_desc(32, 1'b0, 32'hA000_0020, 32'hB000_0020, 32'd8, 32'd48, 1'b1);
        put_desc(48, 1'b1, 32'hA000_0030, 32'hB000_0030, 32'd12, 32'd16, 1'b1);
        wr_reg(3'd1, 32'h0);
        wait_idle();
        chk("R8 two more transfers", nxfer, 3);
        chk("R8 resumed at next pointer", log_src[1], 32'hA000_0020);
        chk("R5 chained descriptor", log_src[2], 32'hA000_0030);
        chk("R5 chained length", log_len[2], 32'd12);
        chk("R4 first of chain written", mem[36], 32'h0000_005A);
        chk("R4 second of chain written", mem[52], 32'h0000_005A);
        rd_reg(3'd3, v); chk("R4 last-finished chain", v, 32'd48);
        wr_reg(3'd5, 32'h2);
    endtask

    task automatic t_ring();
        logic [31:0] v;
        put_desc(100, 1'b0, 32'hC000_0100, 32'hD000_0100, 32'd4, 32'd110, 1'b1);
        put_desc(110, 1'b0, 32'hC000_0110, 32'hD000_0110, 32'd5, 32'd120, 1'b1);
        put_desc(120, 1'b0, 32'hC000_0120, 32'hD000_0120, 32'd6, 32'd100, 1'b1);
        wr_reg(3'd3, 32'h0);
        wr_reg(3'd2, 32'd100);
        wr_reg(3'd1, 32'h0);
        wait_idle();
        chk("R5 ring walked once", nxfer, 6);
        chk("R5 ring last before wrap", log_src[5], 32'hC000_0120);
        chk("R9 error event", {29'h0, irq, 2'b00} & 32'h4, 32'h4);
        rd_reg(3'd5, v); chk("R9 event bits", v, 32'h4);
        rd_reg(3'd1, v); chk("R9 halt bit set", v, 32'h1);
        rd_reg(3'd3, v); chk("R9 last-finished unchanged", v, 32'd120);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        put_desc(140, 1'b0, 32'hE000_0140, 32'hF000_0140, 32'd9, 32'd150, 1'b1);
        put_desc(150, 1'b0, 32'hE000_0150, 32'hF000_0150, 32'd9, 32'd160, 1'b1);
        put_desc(160, 1'b1, 32'hE000_0160, 32'hF000_0160, 32'd9, 32'd140, 1'b1);
        hold = 20;
        wr_reg(3'd3, 32'h0);
        wr_reg(3'd2, 32'd140);
        wr_reg(3'd1, 32'h0);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (xfer_req) break;
        end
        wr_reg(3'd0, 32'h0);
        wait_idle();
        chk("R7 only current completes", nxfer, 7);
        chk("R7 current written back", mem[144], 32'h0000_005A);
        chk("R7 next untouched", mem[154], 32'h8000_005A);
        rd_reg(3'd3, v); chk("R7 last-finished", v, 32'd140);
        rd_reg(3'd5, v); chk("R7 ack with old error", v, 32'h5);
        wr_reg(3'd5, 32'h1);
        rd_reg(3'd5, v); chk("R10 selective clear", v, 32'h4);
        wr_reg(3'd5, 32'h4);
        rd_reg(3'd5, v); chk("R10 last bit cleared", v, 32'h0);
        chk("R12 irq low at end", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_clear();
        t_resume();
        t_ring();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule